// File: doc/BRIEF.md
# Composite Sync Vertical Separator

This block recovers the vertical timing from a composite sync stream, for example the digital sync produced by slicing a sync-on-green signal. It runs on a slow dedicated clock (nominally about 5 MHz). It measures how many consecutive clock periods the synchronized sync input holds a new level. A level that persists for a programmable number of periods becomes the separator output. Shorter excursions, such as horizontal line pulses, are discarded. Software sets that number above the widest horizontal pulse, and its intended power-up value is 32.

A source selector then chooses between the separator output and a dedicated vertical sync pin. In automatic mode the pin is used while it shows recent edges, and the separator is used once the pin has been quiet for a timeout window. An override bit lets software force either source. A final polarity control either inverts the chosen signal or passes it through. The inverting setting is the intended default.

Top module: `vsync_separator`

## Requirements
- R1: The separator output takes a new level once the synchronized composite input has differed from the current output for `sep_thresh` consecutive clock periods. A threshold of 0 behaves as 1. Counted from the first rising edge that samples the new input level, the output changes after edge `sep_thresh`+2, so a run of L ≥ `sep_thresh` periods reproduces an output pulse exactly L periods wide.
- R2: A run shorter than `sep_thresh` periods is rejected and leaves the output unchanged. Any return of the input to the current output level clears the run count, so two short runs separated by a one-period gap are still rejected.
- R3: After reset the separator output is 0 and no pin activity is recorded. With `src_override`=0 and `out_noinvert`=0, `vsync_out` is therefore 1.
- R4: With `src_override`=1, `src_select`=0 picks the vertical sync pin and `src_select`=1 picks the separator output. The pin path has a latency of two clock edges.
- R5: With `src_override`=0, an edge on the pin selects the pin as soon as it reaches the synchronizer output. The pin stays selected until ACT_TIMEOUT edges after the edge detector register has captured the edge. After that the separator output is selected.
- R6: `out_noinvert`=0 drives `vsync_out` as the inverse of the selected source, and `out_noinvert`=1 drives it unchanged. The control bits act combinationally on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow separator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csync_in | input | 1 | Composite sync, asynchronous |
| vsync_pin | input | 1 | Dedicated vertical sync input, asynchronous |
| sep_thresh | input | THR_W | Minimum run length in clock periods |
| src_override | input | 1 | 1: source taken from `src_select`; 0: automatic |
| src_select | input | 1 | 0: pin, 1: separator (when overriding) |
| out_noinvert | input | 1 | 0: invert output, 1: pass through |
| vsync_out | output | 1 | Vertical sync result |

## Verification
The bench sweeps small thresholds, including zero, against every pulse length up to a few beyond each threshold. It checks both the cycle at which the output rises and the width of the pulse it reproduces. An off-by-one in the run counter would move that rise or accept a pulse one period too short. Runs split by a one-period gap target a counter that fails to clear, which would let such runs add up and pass. A timed activity window on the pin, together with an exhaustive sweep of the three control bits over all pin and separator levels, exposes two further faults: a timeout that expires early or late, and a swapped source or polarity.

// File: rtl/vsync_separator.sv
module vsync_separator #(
  parameter int THR_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ACT_TIMEOUT = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csync_in,
  input  logic             vsync_pin,
  input  logic [THR_W-1:0] sep_thresh,
  input  logic             src_override,
  input  logic             src_select,
  input  logic             out_noinvert,
  output logic             vsync_out
);
  localparam int TMR_W = $clog2(ACT_TIMEOUT + 1);

  logic [SYNC_STAGES-1:0] cs_pipe;
  logic [SYNC_STAGES:0]   pin_pipe;
  logic [THR_W-1:0]       cnt;
  logic [TMR_W-1:0]       act_timer;
  logic                   sep_q;

  logic cs_s, pin_s, pin_edge, run_done, pin_live, use_sep, src;

  assign cs_s     = cs_pipe[SYNC_STAGES-1];
  assign pin_s    = pin_pipe[SYNC_STAGES-1];
  assign pin_edge = pin_s ^ pin_pipe[SYNC_STAGES];
  assign run_done = ({1'b0, cnt} + (THR_W+1)'(1)) >= {1'b0, sep_thresh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe  <= '0;
      pin_pipe <= '0;
    end else begin
      cs_pipe  <= {cs_pipe[SYNC_STAGES-2:0], csync_in};
      pin_pipe <= {pin_pipe[SYNC_STAGES-1:0], vsync_pin};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sep_q <= 1'b0;
    end else if (cs_s == sep_q) begin
      cnt <= '0;
    end else if (run_done) begin
      sep_q <= cs_s;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      act_timer <= '0;
    else if (pin_edge)
      act_timer <= TMR_W'(ACT_TIMEOUT);
    else if (act_timer != '0)
      act_timer <= act_timer - 1'b1;
  end

  assign pin_live  = pin_edge | (act_timer != '0);
  assign use_sep   = src_override ? src_select : ~pin_live;
  assign src       = use_sep ? sep_q : pin_s;
  assign vsync_out = out_noinvert ? src : ~src;
endmodule

// File: rtl/vsync_separator_chk.sv
module vsync_separator_chk #(
  parameter int THR_W       = 8,
  parameter int TMR_W       = 18,
  parameter int ACT_TIMEOUT = 250000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vsync_pin,
  input logic [THR_W-1:0] sep_thresh,
  input logic             src_override,
  input logic             src_select,
  input logic             out_noinvert,
  input logic             vsync_out,
  input logic             cs_s,
  input logic             sep_q,
  input logic [THR_W-1:0] cnt,
  input logic             pin_edge,
  input logic [TMR_W-1:0] act_timer
);
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;

  p_toggle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd1 && !$stable(sep_q)) |-> sep_q == $past(cs_s));

  p_toggle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd1 && !$stable(sep_q)) |->
      ({1'b0, $past(cnt)} + (THR_W+1)'(1)) >= {1'b0, $past(sep_thresh)});

  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s == sep_q) |=> cnt == '0);

  p_pin_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd3 && src_override && !src_select && out_noinvert) |->
      vsync_out == $past(vsync_pin, 2));

  p_timer_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_edge |=> act_timer == TMR_W'(ACT_TIMEOUT));

  p_timer_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_edge && act_timer != '0) |=> act_timer == $past(act_timer) - 1'b1);
endmodule

bind vsync_separator vsync_separator_chk #(
  .THR_W(THR_W), .TMR_W(TMR_W), .ACT_TIMEOUT(ACT_TIMEOUT)
) u_chk (.*);

// File: tb/tb_vsync_separator.sv
`timescale 1ns/1ps
module tb_vsync_separator;
  localparam int CLK_PERIOD = 200;
  localparam int TIMEOUT    = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csync_in = 1'b0;
  logic       vsync_pin = 1'b0;
  logic [7:0] sep_thresh = 8'd32;
  logic       src_override = 1'b0;
  logic       src_select = 1'b0;
  logic       out_noinvert = 1'b0;
  logic       vsync_out;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsync_separator #(.THR_W(8), .SYNC_STAGES(2), .ACT_TIMEOUT(TIMEOUT)) dut (
    .clk(clk), .rst_n(rst_n), .csync_in(csync_in), .vsync_pin(vsync_pin),
    .sep_thresh(sep_thresh), .src_override(src_override), .src_select(src_select),
    .out_noinvert(out_noinvert), .vsync_out(vsync_out));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_pattern(input logic [63:0] mask, input int win,
                             output int first_hi, output int hi_cnt);
    first_hi = -1;
    hi_cnt   = 0;
    csync_in = mask[0];
    for (int j = 1; j <= win; j++) begin
      @(negedge clk);
      if (vsync_out) begin
        if (first_hi < 0) first_hi = j;
        hi_cnt++;
      end
      csync_in = (j < 64) ? mask[j] : 1'b0;
    end
    csync_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int fh, hc, teff;
    logic [63:0] m;
    idle(3);
    rst_n = 1'b1;
    #1;
    chk("R3 reset output inverted", int'(vsync_out), 1);
    src_override = 1'b1; src_select = 1'b1; out_noinvert = 1'b1;
    #1;
    chk("R3 reset separator level", int'(vsync_out), 0);

    // R1 / R2: threshold sweep against pulse length
    for (int t = 0; t <= 6; t++) begin
      sep_thresh = 8'(t);
      teff = (t == 0) ? 1 : t;
      idle(10);
      for (int l = 1; l <= 8; l++) begin
        m = (64'd1 << l) - 64'd1;
        run_pattern(m, l + teff + 6, fh, hc);
        chk($sformatf("R1 rise cycle T=%0d L=%0d", t, l), fh, (l >= teff) ? teff + 2 : -1);
        chk($sformatf("R1/R2 width T=%0d L=%0d", t, l), hc, (l >= teff) ? l : 0);
      end
    end

    // R2: two short runs with a one-period gap are rejected
    for (int t = 2; t <= 6; t++) begin
      sep_thresh = 8'(t);
      idle(10);
      m = ((64'd1 << (t-1)) - 64'd1) | (((64'd1 << (t-1)) - 64'd1) << t);
      run_pattern(m, 3*t + 6, fh, hc);
      chk($sformatf("R2 split runs T=%0d", t), hc, 0);
      idle(4);
      m = ((64'd1 << (2*t+4)) - 64'd1) & ~(((64'd1 << (t-1)) - 64'd1) << (t+3));
      run_pattern(m, 3*t + 10, fh, hc);
      chk($sformatf("R2 short dip rise T=%0d", t), fh, t + 2);
      chk($sformatf("R2 short dip width T=%0d", t), hc, 2*t + 4);
    end

    // R1 at the intended default threshold
    sep_thresh = 8'd32;
    idle(40);
    run_pattern((64'd1 << 31) - 64'd1, 31 + 32 + 6, fh, hc);
    chk("R1 default T=32 L=31 rejected", hc, 0);
    run_pattern((64'd1 << 32) - 64'd1, 32 + 32 + 6, fh, hc);
    chk("R1 default T=32 L=32 rise", fh, 34);
    chk("R1 default T=32 L=32 width", hc, 32);

    // R4: pin path latency under override
    sep_thresh = 8'd4;
    idle(10);
    src_override = 1'b1; src_select = 1'b0; out_noinvert = 1'b1;
    vsync_pin = 1'b1;
    @(negedge clk);
    chk("R4 pin rise after 1 edge", int'(vsync_out), 0);
    @(negedge clk);
    chk("R4 pin rise after 2 edges", int'(vsync_out), 1);
    vsync_pin = 1'b0;
    @(negedge clk);
    chk("R4 pin fall after 1 edge", int'(vsync_out), 1);
    @(negedge clk);
    chk("R4 pin fall after 2 edges", int'(vsync_out), 0);

    // R5: automatic selection window
    idle(TIMEOUT + 10);
    src_override = 1'b0;
    #1;
    chk("R5 idle pin selects separator", int'(vsync_out), 0);
    vsync_pin = 1'b1;
    @(negedge clk);
    chk("R5 before edge reaches sync", int'(vsync_out), 0);
    @(negedge clk);
    chk("R5 pin selected on edge", int'(vsync_out), 1);
    idle(TIMEOUT);
    chk("R5 last cycle of window", int'(vsync_out), 1);
    @(negedge clk);
    chk("R5 window expired", int'(vsync_out), 0);

    // R4 / R5 / R6: exhaustive control sweep with the timer expired
    for (int sv = 0; sv <= 1; sv++) begin
      for (int pv = 0; pv <= 1; pv++) begin
        csync_in  = 1'(sv);
        vsync_pin = 1'(pv);
        idle(TIMEOUT + 20);
        for (int c = 0; c < 8; c++) begin
          int src, exp;
          src_override = c[2]; src_select = c[1]; out_noinvert = c[0];
          #1;
          src = (c[2] && !c[1]) ? pv : sv;
          exp = c[0] ? src : 1 - src;
          chk($sformatf("R4/R6 sweep sep=%0d pin=%0d ctl=%0d", sv, pv, c), int'(vsync_out), exp);
          @(negedge clk);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule